// File: doc/BRIEF.md
# Split-Word Mailbox FIFO Reader

This block queues 64-bit mailbox messages that arrive from a receive datapath and hands them to a host whose register bus is only 32 bits wide. The datapath pushes a whole 64-bit entry in one cycle. The host reads the entry at the head of the queue as two 32-bit words from two read-only register offsets.

The host reads the low word first, then the high word. Only the high-word read consumes the entry. A read of the low word can therefore be repeated without losing data, and a message leaves the queue only once both halves have been fetched.

The block has flags for empty and full, a not-empty flag for an interrupt line, and a sticky flag that records a dropped push. It runs on one clock, and its depth is a parameter.

Top module: `mbox_fifo`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0, `msg_pending` is 0 and `overflow` is 0.
- R2: Entries leave in the order they were pushed. While `reg_rd` is high with `reg_addr` = 0xF0310, `reg_rdata` shows bits 31:0 of the head entry in the same cycle. With `reg_addr` = 0xF0314 it shows bits 63:32.
- R3: A read at 0xF0314 while the queue is not empty removes the head entry at the next clock edge.
- R4: A read at 0xF0310 leaves the queue unchanged, so repeated low-word reads return the same word.
- R5: A read at either offset while the queue is empty returns zero and changes nothing.
- R6: After DEPTH entries are held, `fifo_full` is 1. A push into a full queue with no pop in the same cycle is dropped, and `overflow` is set. `overflow` then stays set until reset.
- R7: A push and a high-word pop in the same cycle are both honoured, including when the queue is full. The occupancy stays the same.
- R8: A read at any other offset returns zero and does not change the queue. A high-word address with `reg_rd` low does not pop.
- R9: `msg_pending` equals the inverse of `fifo_empty` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push strobe from the receive datapath |
| push_data | input | 64 | Message to enqueue |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 20 | Host register offset |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| msg_pending | output | 1 | Queue is not empty (interrupt source) |
| overflow | output | 1 | Sticky: a push was dropped |

## Verification
- **Distinct words:** Each message carries distinct low and high words that encode its index. A half-swap or an off-by-one head is therefore visible on every read.
- **Order and boundaries:** Filling the queue to DEPTH and then draining it checks the order and both boundary flags. An extra push at full separates a dropped push from one that overwrites the head.
- **Repeated reads:** Reading the low word twice before the high word, reading an empty queue, and reading a foreign offset separate reads that have side effects from reads that do not.
- **Push with pop:** Push-with-pop cycles, run both part-full and at full, tell a queue that honours both operations from one that favours either.

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DEPTH = 8,
  parameter logic [19:0] LO_OFS = 20'hF0310,
  parameter logic [19:0] HI_OFS = 20'hF0314
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [63:0] push_data,
  input  logic        reg_rd,
  input  logic [19:0] reg_addr,
  output logic [31:0] reg_rdata,
  output logic        fifo_empty,
  output logic        fifo_full,
  output logic        msg_pending,
  output logic        overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [63:0]   mem [DEPTH];
  logic [IW-1:0] rd_idx, wr_idx;
  logic [CW-1:0] count;
  logic          sel_lo, sel_hi, pop, push;
  logic [63:0]   head;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign sel_lo      = reg_rd && (reg_addr == LO_OFS);
  assign sel_hi      = reg_rd && (reg_addr == HI_OFS);
  assign fifo_empty  = (count == '0);
  assign fifo_full   = (count == CW'(DEPTH));
  assign msg_pending = !fifo_empty;
  assign pop         = sel_hi && !fifo_empty;
  assign push        = push_valid && (!fifo_full || pop);
  assign head        = mem[rd_idx];

  always_comb begin
    reg_rdata = '0;
    if (!fifo_empty) begin
      if (sel_lo)      reg_rdata = head[31:0];
      else if (sel_hi) reg_rdata = head[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx   <= '0;
      wr_idx   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_idx <= step(wr_idx);
      if (pop)  rd_idx <= step(rd_idx);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_valid && !push) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/mbox_fifo_chk.sv
module mbox_fifo_chk #(
  parameter int DEPTH = 8,
  parameter logic [19:0] LO_OFS = 20'hF0310,
  parameter logic [19:0] HI_OFS = 20'hF0314
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         push_valid,
  input logic                         reg_rd,
  input logic [19:0]                  reg_addr,
  input logic [31:0]                  reg_rdata,
  input logic                         fifo_empty,
  input logic                         fifo_full,
  input logic                         msg_pending,
  input logic                         overflow,
  input logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH + 1);
  logic hi_rd, lo_rd;
  assign hi_rd = reg_rd && (reg_addr == HI_OFS);
  assign lo_rd = reg_rd && (reg_addr == LO_OFS);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));
  p_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pending == !fifo_empty);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fifo_full && !hi_rd) |=> (overflow && fifo_full));
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && fifo_empty) |-> (reg_rdata == 32'h0));
  p_lo_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rd && !push_valid) |=> $stable(count));
  p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !fifo_empty && !push_valid) |=> (count == CW'($past(count) - 1'b1)));
  p_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !fifo_empty && push_valid) |=> $stable(count));
endmodule

bind mbox_fifo mbox_fifo_chk #(.DEPTH(DEPTH), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .msg_pending(msg_pending), .overflow(overflow),
  .count(count)
);

// File: tb/mbox_fifo_tb.sv
`timescale 1ns/1ps
module mbox_fifo_tb_top;
  localparam int DEPTH = 8;
  localparam logic [19:0] LO = 20'hF0310;
  localparam logic [19:0] HI = 20'hF0314;

  logic clk = 0, rst_n = 0, push_valid = 0, reg_rd = 0;
  logic [63:0] push_data = '0;
  logic [19:0] reg_addr = '0;
  logic [31:0] reg_rdata;
  logic fifo_empty, fifo_full, msg_pending, overflow;

  int total = 0, bad = 0;
  logic [63:0] q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  mbox_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [63:0] d);
    @(negedge clk);
    push_valid = 1; push_data = d;
    if (q.size() < DEPTH) q.push_back(d);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic rd(logic [19:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic pop_check(string req);
    logic [31:0] lo, hi;
    logic [63:0] e;
    e = q.pop_front();
    rd(LO, lo);
    check(req, lo, e[31:0]);
    rd(HI, hi);
    check(req, hi, e[63:32]);
  endtask

  task automatic push_pop(logic [63:0] d, string req);
    logic [63:0] e;
    @(negedge clk);
    push_valid = 1; push_data = d; reg_rd = 1; reg_addr = HI;
    e = q.pop_front();
    q.push_back(d);
    #1 check(req, reg_rdata, e[63:32]);
    @(negedge clk);
    push_valid = 0; reg_rd = 0;
  endtask

  function automatic logic [63:0] pat(int i);
    return {32'hA5000000 | i, 32'h3C000000 | (i << 4)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 empty", fifo_empty, 1);
    check("R1 full", fifo_full, 0);
    check("R1 pending", msg_pending, 0);
    check("R1 overflow", overflow, 0);

    // R5: empty reads return zero, no state change
    rd(LO, v); check("R5 lo", v, 0);
    rd(HI, v); check("R5 hi", v, 0);
    check("R5 still empty", fifo_empty, 1);

    push(pat(1)); push(pat(2)); push(pat(3));
    #1 check("R9 pending", msg_pending, 1);
    // R4: repeated low-word reads
    rd(LO, v); rd(LO, v2);
    check("R4 repeat", v2, v);
    check("R4 value", v, pat(1) & 64'hFFFFFFFF);
    // R8: foreign offset and idle strobe
    rd(20'hF0318, v); check("R8 other zero", v, 0);
    @(negedge clk); reg_addr = HI; @(negedge clk);
    pop_check("R3 first");
    pop_check("R2 second");
    pop_check("R2 third");
    #1 check("R3 empty after drain", fifo_empty, 1);
    check("R9 not pending", msg_pending, 0);

    // R6: fill, overflow, sticky
    for (int i = 10; i < 10 + DEPTH; i++) push(pat(i));
    #1 check("R6 full", fifo_full, 1);
    check("R6 no overflow yet", overflow, 0);
    push(pat(99));
    #1 check("R6 overflow set", overflow, 1);
    check("R6 still full", fifo_full, 1);
    // R7 at full
    push_pop(pat(50), "R7 full pop word");
    #1 check("R7 full kept", fifo_full, 1);
    while (q.size() > 0) pop_check("R2 drain order");
    #1 check("R6 drained empty", fifo_empty, 1);
    check("R6 overflow sticky", overflow, 1);

    // R7 part-full
    push(pat(60)); push(pat(61));
    push_pop(pat(62), "R7 pop word");
    pop_check("R7 order a");
    pop_check("R7 order b");
    #1 check("R7 empty", fifo_empty, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule